// File: doc/BRIEF.md
# Request/Acknowledge Word Crossing Channel

This block moves a multi-bit binary word, such as a FIFO pointer whose depth is not a power of two, from one clock domain into another unrelated one. A plain binary value can change in several bits at once, so it cannot be sampled directly across the boundary. Instead, the sending side latches the word into a holding register and raises a request level. It keeps the word frozen until the whole four-phase request/acknowledge exchange has finished.

On the receiving side the request passes through a multi-stage synchronizer. Once it is seen high, the held word is captured, a one-cycle valid pulse is issued and an acknowledge level is raised. The acknowledge goes back through its own synchronizer. The sender then drops the request, waits for the acknowledge to drop, and only then may start a new transfer. A load that arrives while a transfer is in flight is not lost. It is parked, newer parked loads overwrite older ones, and the newest parked word is sent as soon as the channel is free. This suits pointers, where only the latest value matters.

Top module: `handshake_bus_sync`

## Requirements
- R1: While reset is applied, src_busy is 0, dst_valid is 0 and dst_value is 0.
- R2: A load accepted while src_busy is 0 delivers exactly that word on dst_value, in the destination cycle where dst_valid is 1.
- R3: dst_valid is a single-cycle pulse. Each completed transfer produces exactly one pulse, and it is never high in two consecutive destination cycles.
- R4: dst_value changes only in a cycle where dst_valid is 1, and holds its value otherwise.
- R5: Loads made while src_busy is 1 are deferred. After the current transfer, only the most recent of them is sent, and earlier deferred words never appear at the destination.
- R6: src_busy goes to 1 in the source cycle after an accepted load. It stays 1 until the acknowledge of the last transfer, including any deferred one, has returned low, and then goes to 0.
- R7: Request and acknowledge each cross through SYNC_STAGES (at least 2) flip-flops in the receiving domain. dst_valid therefore appears no sooner than SYNC_STAGES+1 destination clock edges after the source edge that accepts a load.
- R8: The request is a four-phase level. It stays high until the synchronized acknowledge is 1. A new request rises only while the synchronized acknowledge is 0. The held word does not change except when a new request starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_load | input | 1 | Request to send src_value |
| src_value | input | WIDTH | Word to send |
| src_busy | output | 1 | A transfer is in flight; loads now are deferred |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous |
| dst_value | output | WIDTH | Last captured word |
| dst_valid | output | 1 | One-cycle pulse when dst_value has just been updated |

## Verification
The bench sweeps every word of a 6-bit configuration through the channel one at a time. It checks that each word arrives intact, with a single valid pulse and with no fewer destination edges of latency than the synchronizer depth allows. A design that sampled the bus before the request was synchronized would show a short latency. A design that let the word move during the exchange would deliver a corrupted value. A burst of loads against a busy channel checks that only the first and the newest words arrive. A design that queued every load, or dropped the deferred one, would deliver the wrong count or the wrong word. Busy is checked both in the middle of a chained transfer and after it drains, which catches a sender that releases busy before the acknowledge has returned low.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_REQ  = 2'd1,
        SRC_DROP = 2'd2
    } src_phase_e;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] ff_d;
    logic [LAST:0] ff_q;

    always_comb begin
        ff_d[0] = d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_comb begin
            ff_d[i] = ff_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '0;
        end else begin
            ff_q <= ff_d;
        end
    end

    assign q = ff_q[LAST];

endmodule

// File: rtl/hbs_src.sv
module hbs_src
    import hbs_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] value,
    input  logic             ack_sync,
    output logic             req,
    output logic             busy,
    output logic [WIDTH-1:0] hold
);
    typedef struct packed {
        src_phase_e       phase;
        logic [WIDTH-1:0] hold;
        logic             pend;
        logic [WIDTH-1:0] pend_val;
    } src_state_t;

    src_state_t s_d;
    src_state_t s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            SRC_IDLE: begin
                if (load) begin
                    s_d.hold  = value;
                    s_d.phase = SRC_REQ;
                end
            end
            SRC_REQ: begin
                if (load) begin
                    s_d.pend     = 1'b1;
                    s_d.pend_val = value;
                end
                if (ack_sync) begin
                    s_d.phase = SRC_DROP;
                end
            end
            SRC_DROP: begin
                if (load) begin
                    s_d.pend     = 1'b1;
                    s_d.pend_val = value;
                end
                if (!ack_sync) begin
                    if (load) begin
                        s_d.hold  = value;
                        s_d.pend  = 1'b0;
                        s_d.phase = SRC_REQ;
                    end else if (s_q.pend) begin
                        s_d.hold  = s_q.pend_val;
                        s_d.pend  = 1'b0;
                        s_d.phase = SRC_REQ;
                    end else begin
                        s_d.phase = SRC_IDLE;
                    end
                end
            end
            default: begin
                s_d.phase = SRC_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: SRC_IDLE, hold: '0, pend: 1'b0, pend_val: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req  = (s_q.phase == SRC_REQ);
    assign busy = (s_q.phase != SRC_IDLE);
    assign hold = s_q.hold;

endmodule

// File: rtl/hbs_dst.sv
module hbs_dst #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic [WIDTH-1:0] bus,
    output logic             ack,
    output logic             valid,
    output logic [WIDTH-1:0] value
);
    typedef struct packed {
        logic             ack;
        logic             valid;
        logic [WIDTH-1:0] value;
    } dst_state_t;

    dst_state_t s_d;
    dst_state_t s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (req_sync && !s_q.ack) begin
            s_d.value = bus;
            s_d.valid = 1'b1;
            s_d.ack   = 1'b1;
        end else if (!req_sync && s_q.ack) begin
            s_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ack: 1'b0, valid: 1'b0, value: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ack   = s_q.ack;
    assign valid = s_q.valid;
    assign value = s_q.value;

endmodule

// File: rtl/handshake_bus_sync.sv
module handshake_bus_sync #(
    parameter int WIDTH       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_load,
    input  logic [WIDTH-1:0] src_value,
    output logic             src_busy,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [WIDTH-1:0] dst_value,
    output logic             dst_valid
);
    localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic             src_req;
    logic             src_ack_sync;
    logic [WIDTH-1:0] src_hold;
    logic             dst_req_sync;
    logic             dst_ack;

    hbs_src #(.WIDTH(WIDTH)) u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .load     (src_load),
        .value    (src_value),
        .ack_sync (src_ack_sync),
        .req      (src_req),
        .busy     (src_busy),
        .hold     (src_hold)
    );

    hbs_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (src_req),
        .q     (dst_req_sync)
    );

    hbs_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (dst_ack),
        .q     (src_ack_sync)
    );

    hbs_dst #(.WIDTH(WIDTH)) u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .req_sync (dst_req_sync),
        .bus      (src_hold),
        .ack      (dst_ack),
        .valid    (dst_valid),
        .value    (dst_value)
    );

endmodule

// File: rtl/handshake_bus_sync_chk.sv
module handshake_bus_sync_chk #(
    parameter int WIDTH = 10
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             src_busy,
    input logic             src_req,
    input logic             src_ack_sync,
    input logic [WIDTH-1:0] src_hold,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic             dst_valid,
    input logic [WIDTH-1:0] dst_value,
    input logic             dst_req_sync,
    input logic             dst_ack
);
    assert_valid_single_R3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |=> !dst_valid);

    assert_ack_rise_with_valid_R3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $rose(dst_ack) |-> (dst_valid && dst_req_sync));

    assert_value_hold_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_valid |-> $stable(dst_value));

    assert_busy_covers_req_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_req |-> src_busy);

    assert_req_rise_ack_low_R8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(src_req) |-> !src_ack_sync);

    assert_req_held_R8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_req && !src_ack_sync) |=> src_req);

    assert_hold_frozen_R8: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !$rose(src_req) |-> $stable(src_hold));

endmodule

bind handshake_bus_sync handshake_bus_sync_chk #(.WIDTH(WIDTH)) u_chk (
    .src_clk      (src_clk),
    .src_rst_n    (src_rst_n),
    .src_busy     (src_busy),
    .src_req      (src_req),
    .src_ack_sync (src_ack_sync),
    .src_hold     (src_hold),
    .dst_clk      (dst_clk),
    .dst_rst_n    (dst_rst_n),
    .dst_valid    (dst_valid),
    .dst_value    (dst_value),
    .dst_req_sync (dst_req_sync),
    .dst_ack      (dst_ack)
);

// File: tb/handshake_bus_sync_bench.sv
module handshake_bus_sync_bench;
    localparam int W    = 6;
    localparam int SYNC = 2;

    logic         src_clk = 1'b0;
    logic         dst_clk = 1'b0;
    logic         src_rst_n = 1'b0;
    logic         dst_rst_n = 1'b0;
    logic         src_load = 1'b0;
    logic [W-1:0] src_value = '0;
    logic         src_busy;
    logic [W-1:0] dst_value;
    logic         dst_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int dst_edges = 0;
    int load_mark = 0;
    bit lat_en    = 1'b0;
    bit mon_en    = 1'b0;
    bit prev_valid = 1'b0;
    logic [W-1:0] last_value = '0;
    logic [W-1:0] got [$];

    always #5 src_clk = ~src_clk;     // 100 MHz
    always #13.5 dst_clk = ~dst_clk;  // unrelated destination clock

    handshake_bus_sync #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_handshake_bus_sync (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_load  (src_load),
        .src_value (src_value),
        .src_busy  (src_busy),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_value (dst_value),
        .dst_valid (dst_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge src_clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_run();
        end
    end

    always @(posedge dst_clk) dst_edges++;

    // destination monitor
    always @(negedge dst_clk) begin
        if (mon_en) begin
            if (dst_valid) begin
                got.push_back(dst_value);
                check(!prev_valid, "R3 back-to-back valid", 1, 0);
                if (lat_en) begin
                    check(dst_edges - load_mark >= SYNC + 1, "R7 latency",
                          dst_edges - load_mark, SYNC + 1);
                end
            end else begin
                check(dst_value == last_value, "R4 value moved without valid",
                      int'(dst_value), int'(last_value));
            end
            prev_valid = dst_valid;
            last_value = dst_value;
        end
    end

    task automatic send_one(input logic [W-1:0] v);
        while (src_busy) @(negedge src_clk);
        src_load  = 1'b1;
        src_value = v;
        @(posedge src_clk);
        #1 load_mark = dst_edges;
        @(negedge src_clk);
        src_load = 1'b0;
        check(src_busy == 1'b1, "R6 busy after load", int'(src_busy), 1);
    endtask

    initial begin
        repeat (4) @(negedge src_clk);
        check(src_busy == 1'b0, "R1 busy in reset", int'(src_busy), 0);
        check(dst_valid == 1'b0, "R1 valid in reset", int'(dst_valid), 0);
        check(dst_value == '0, "R1 value in reset", int'(dst_value), 0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        mon_en    = 1'b1;
        repeat (4) @(negedge src_clk);

        // R2/R7: sweep every word
        lat_en = 1'b1;
        for (int v = 0; v < (1 << W); v++) begin
            int n;
            n = got.size();
            send_one(W'((v * 37 + 11) % (1 << W)));
            while (got.size() < n + 1) @(negedge src_clk);
            check(got[n] == W'((v * 37 + 11) % (1 << W)), "R2 delivered word",
                  int'(got[n]), (v * 37 + 11) % (1 << W));
        end
        lat_en = 1'b0;
        repeat (40) @(negedge src_clk);
        check(src_busy == 1'b0, "R6 busy drops when drained", int'(src_busy), 0);
        check(got.size() == (1 << W), "R3 one pulse per transfer", got.size(), 1 << W);

        // R5: burst against a busy channel
        begin
            int n;
            n = got.size();
            while (src_busy) @(negedge src_clk);
            src_load = 1'b1;
            src_value = 6'd5;
            @(negedge src_clk);
            src_value = 6'd42;
            @(negedge src_clk);
            src_value = 6'd17;
            @(negedge src_clk);
            src_load = 1'b0;
            while (got.size() < n + 1) @(negedge src_clk);
            check(got[n] == 6'd5, "R5 first word", int'(got[n]), 5);
            check(src_busy == 1'b1, "R6 busy while deferred pending", int'(src_busy), 1);
            while (got.size() < n + 2) @(negedge src_clk);
            check(got[n+1] == 6'd17, "R5 newest deferred word", int'(got[n+1]), 17);
            repeat (60) @(negedge src_clk);
            check(got.size() == n + 2, "R5 stale word dropped", got.size(), n + 2);
            check(src_busy == 1'b0, "R6 busy cleared after deferred", int'(src_busy), 0);
        end

        // R5: deferred load arriving late in the exchange
        begin
            int n;
            n = got.size();
            send_one(6'd9);
            while (got.size() < n + 1) @(negedge src_clk);
            src_load = 1'b1;
            src_value = 6'd63;
            @(negedge src_clk);
            src_load = 1'b0;
            while (got.size() < n + 2) @(negedge src_clk);
            check(got[n] == 6'd9, "R2 word before late load", int'(got[n]), 9);
            check(got[n+1] == 6'd63, "R5 late deferred word", int'(got[n+1]), 63);
            repeat (60) @(negedge src_clk);
            check(dst_value == 6'd63, "R4 value held", int'(dst_value), 63);
        end

        finish_run();
    end

endmodule